// File: doc/BRIEF.md
# Ladder Logic Scan Engine

This block executes a stored relay-ladder program against a 64-bit internal bit table, in the manner of a programmable logic controller. Each scan has three steps. First it freezes the input bus into the low table bits. Then it steps through the program one instruction per clock, from slot 0 upward. Finally it copies a window of table bits into a separate output register and pulses `scan_done`.

A rung is written as a short instruction sequence. A load contact starts it, series and parallel contacts follow, parenthesised branches go on a small accumulator stack, and a coil stores the rung result into a table bit. A coil written by an earlier rung is seen with its new value by every later rung of the same scan. The output bus changes only at the end of a scan, so an input change reaches the outputs one scan later.

Software fills the program store through a simple write port while the engine is stopped. It then holds `run_en` high for back-to-back scans, or pulses it for a single scan.

Top module: `lscan_engine`

## Requirements
- R1: A synchronous reset clears the bit table, the accumulator stack, the output register and `scan_done`; the program store keeps its contents.
- R2: When the engine is idle and `run_en` is high, the next clock edge copies `in_bus` into table bits 0..NUM_IN-1 and starts execution at slot 0. Changes on `in_bus` after that edge have no effect on the running scan.
- R3: An instruction is 10 bits, with the opcode in bits 9:6 and the table address in bits 5:0. The contact opcodes are 0 load, 2 series (AND) and 4 parallel (OR), each for a normally-open contact that yields the addressed bit. Adding 1 to any of these gives the normally-closed form (1, 3, 5), which yields the inverse of the bit.
- R4: Opcode 6 opens a branch: it pushes the accumulator onto a 4-deep stack and sets the accumulator to 1. Opcode 7 closes it: it pops the stack and ANDs the popped value into the accumulator. A push onto a full stack is dropped, and a pop of an empty stack yields 1.
- R5: Opcode 8 (coil) writes the accumulator into the addressed table bit and leaves the accumulator unchanged. A later instruction in the same scan reads the new value, and an earlier one read the old value.
- R6: A self-holding rung (set OR own bit, AND NOT reset) keeps its bit at 1 after the set input drops, until the reset input is seen; with set and reset both high the bit clears.
- R7: One instruction runs per clock. Opcode 9 to 15 ends the scan, and slot PROG_DEPTH-1 always ends the scan whatever it holds. For a program whose end sits in slot L-1, `scan_done` goes high L+1 clocks after the start edge. It stays high for exactly one cycle and is raised together with the output update.
- R8: `out_bus` equals table bits OUT_BASE..OUT_BASE+NUM_OUT-1 as they stand at the end of the scan. It changes in no cycle in which `scan_done` is low.
- R9: A program write takes effect only while the engine is idle and `run_en` is low; writes during a scan or on the start cycle are ignored.
- R10: While `run_en` stays high, a new scan starts on the edge after each `scan_done`. With `run_en` low at that point, the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start/continue scanning |
| in_bus | input | NUM_IN | Sensor inputs, frozen at scan start |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | $clog2(PROG_DEPTH) | Program slot to write |
| prog_data | input | 10 | Instruction word to write |
| out_bus | output | NUM_OUT | Actuator outputs, updated once per scan |
| scan_done | output | 1 | One-cycle pulse at end of each scan |

## Verification
Several rules are checked on every cycle by the assertions. They cover the single-cycle done pulse and the output bus holding between pulses. They also check that program writes are locked out during a scan, that input sampling lands in the table, that coils write only during execution, that the stack pointer stays bounded, the reset state, and the restart from the done cycle. Only the bench's scenarios can show the logical results. These include contact polarity, series/parallel/branch evaluation, the difference between reading a bit before and after its coil in one scan, latch holding, scan length in cycles, and the fact that a late input change or a locked-out program write leaves the outputs untouched.

// File: rtl/lscan_pkg.sv
package lscan_pkg;
  localparam int OP_W    = 4;
  localparam int BADDR_W = 6;
  localparam int INSTR_W = OP_W + BADDR_W;

  typedef enum logic [OP_W-1:0] {
    OP_LD_NO    = 4'd0,
    OP_LD_NC    = 4'd1,
    OP_AND_NO   = 4'd2,
    OP_AND_NC   = 4'd3,
    OP_OR_NO    = 4'd4,
    OP_OR_NC    = 4'd5,
    OP_BR_OPEN  = 4'd6,
    OP_BR_CLOSE = 4'd7,
    OP_COIL     = 4'd8,
    OP_END      = 4'd9
  } op_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_EXEC = 1'b1} scan_state_e;

  // Contact value: odd opcodes invert the addressed bit (R3).
  function automatic logic contact_out(input logic bit_v, input logic [OP_W-1:0] op);
    return bit_v ^ op[0];
  endfunction

  // Accumulator update for the contact opcodes (R3).
  function automatic logic rung_combine(input logic acc, input logic c,
                                        input logic [OP_W-1:0] op);
    logic r;
    case (op)
      OP_AND_NO, OP_AND_NC: r = acc & c;
      OP_OR_NO,  OP_OR_NC:  r = acc | c;
      default:              r = c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lscan_prog_mem.sv
module lscan_prog_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 10
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  assign rd_data = slots[rd_addr];
endmodule

// File: rtl/lscan_acc_stack.sv
module lscan_acc_stack #(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       push,
  input  logic                       push_val,
  input  logic                       pop,
  output logic                       top_val,
  output logic [$clog2(DEPTH+1)-1:0] depth_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int SLOTS = 1 << SP_W;

  logic [SP_W-1:0]  sp_q;
  logic [SLOTS-1:0] cells_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sp_q    <= '0;
      cells_q <= '0;
    end else if (push) begin
      if (sp_q < SP_W'(DEPTH)) begin
        cells_q[sp_q] <= push_val;
        sp_q          <= sp_q + 1'b1;
      end
    end else if (pop) begin
      if (sp_q != '0) sp_q <= sp_q - 1'b1;
    end
  end

  // Empty stack pops as 1 so the closing AND is neutral.
  assign top_val = (sp_q == '0) ? 1'b1 : cells_q[sp_q - 1'b1];
  assign depth_o = sp_q;
endmodule

// File: rtl/lscan_bit_table.sv
module lscan_bit_table #(
  parameter int BITS   = 64,
  parameter int NUM_IN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_en,
  input  logic [NUM_IN-1:0]       in_bits,
  input  logic                    wr_en,
  input  logic [$clog2(BITS)-1:0] wr_addr,
  input  logic                    wr_val,
  input  logic [$clog2(BITS)-1:0] rd_addr,
  output logic                    rd_bit,
  output logic [BITS-1:0]         bits_o
);
  logic [BITS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else begin
      if (sample_en) bits_q[NUM_IN-1:0] <= in_bits;
      if (wr_en)     bits_q[wr_addr]    <= wr_val;
    end
  end

  assign rd_bit = bits_q[rd_addr];
  assign bits_o = bits_q;
endmodule

// File: rtl/lscan_engine.sv
module lscan_engine
  import lscan_pkg::*;
#(
  parameter int NUM_IN      = 8,
  parameter int NUM_OUT     = 8,
  parameter int OUT_BASE    = 8,
  parameter int PROG_DEPTH  = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run_en,
  input  logic [NUM_IN-1:0]             in_bus,
  input  logic                          prog_we,
  input  logic [$clog2(PROG_DEPTH)-1:0] prog_addr,
  input  logic [9:0]                    prog_data,
  output logic [NUM_OUT-1:0]            out_bus,
  output logic                          scan_done
);
  localparam int PC_W       = $clog2(PROG_DEPTH);
  localparam int TABLE_BITS = 1 << BADDR_W;
  localparam int SP_W       = $clog2(STACK_DEPTH + 1);

  scan_state_e         state_q;
  logic [PC_W-1:0]     pc_q;
  logic                acc_q;
  logic [NUM_OUT-1:0]  out_q;
  logic                done_q;

  // Named internal events (used by the bound checker).
  logic                exec_active, sample_en, mem_we, scan_end, step;
  logic                coil_we, push, pop, is_contact, at_last;
  logic [INSTR_W-1:0]  instr;
  logic [OP_W-1:0]     op_raw;
  logic [BADDR_W-1:0]  baddr;
  logic                rd_bit, pop_val, contact_val;
  logic [TABLE_BITS-1:0] table_bits;
  logic [SP_W-1:0]     stack_depth;

  assign exec_active = (state_q == ST_EXEC);
  assign sample_en   = !exec_active && run_en;
  assign mem_we      = prog_we && !exec_active && !run_en;

  assign op_raw      = instr[INSTR_W-1 -: OP_W];
  assign baddr       = instr[BADDR_W-1:0];
  assign at_last     = (pc_q == PC_W'(PROG_DEPTH - 1));
  assign scan_end    = exec_active && ((op_raw >= OP_END) || at_last);
  assign step        = exec_active && !scan_end;
  assign is_contact  = (op_raw <= OP_OR_NC);
  assign coil_we     = step && (op_raw == OP_COIL);
  assign push        = step && (op_raw == OP_BR_OPEN);
  assign pop         = step && (op_raw == OP_BR_CLOSE);
  assign contact_val = contact_out(rd_bit, op_raw);

  lscan_prog_mem #(.DEPTH(PROG_DEPTH), .WIDTH(INSTR_W)) u_prog (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (prog_addr),
    .wr_data (prog_data),
    .rd_addr (pc_q),
    .rd_data (instr)
  );

  lscan_bit_table #(.BITS(TABLE_BITS), .NUM_IN(NUM_IN)) u_table (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .in_bits   (in_bus),
    .wr_en     (coil_we),
    .wr_addr   (baddr),
    .wr_val    (acc_q),
    .rd_addr   (baddr),
    .rd_bit    (rd_bit),
    .bits_o    (table_bits)
  );

  lscan_acc_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .clear    (sample_en),
    .push     (push),
    .push_val (acc_q),
    .pop      (pop),
    .top_val  (pop_val),
    .depth_o  (stack_depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      acc_q   <= 1'b0;
      out_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!exec_active) begin
        if (run_en) begin
          state_q <= ST_EXEC;
          pc_q    <= '0;
          acc_q   <= 1'b0;
        end
      end else if (scan_end) begin
        out_q   <= table_bits[OUT_BASE +: NUM_OUT];
        done_q  <= 1'b1;
        state_q <= ST_IDLE;
        pc_q    <= '0;
      end else begin
        pc_q <= pc_q + 1'b1;
        if (is_contact)    acc_q <= rung_combine(acc_q, contact_val, op_raw);
        else if (push)     acc_q <= 1'b1;
        else if (pop)      acc_q <= acc_q & pop_val;
      end
    end
  end

  assign out_bus   = out_q;
  assign scan_done = done_q;
endmodule

// File: rtl/lscan_engine_chk.sv
module lscan_engine_chk #(
  parameter int NUM_IN      = 8,
  parameter int NUM_OUT     = 8,
  parameter int TABLE_BITS  = 64,
  parameter int STACK_DEPTH = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           run_en,
  input logic [NUM_IN-1:0]              in_bus,
  input logic [NUM_OUT-1:0]             out_bus,
  input logic                           scan_done,
  input logic                           mem_we,
  input logic                           exec_active,
  input logic                           coil_we,
  input logic                           sample_en,
  input logic [TABLE_BITS-1:0]          table_bits,
  input logic [$clog2(STACK_DEPTH+1)-1:0] stack_depth
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_bus == '0 && !scan_done && table_bits == '0 && stack_depth == '0));

  // R2
  input_sample_chk: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (table_bits[NUM_IN-1:0] == $past(in_bus)));

  // R4
  stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stack_depth <= STACK_DEPTH);

  // R5
  coil_phase_chk: assert property (@(posedge clk) disable iff (rst)
    coil_we |-> exec_active);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !scan_done |-> $stable(out_bus));

  // R9
  prog_lock_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!exec_active && !run_en));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_done && run_en) |-> sample_en);
endmodule

bind lscan_engine lscan_engine_chk #(
  .NUM_IN      (NUM_IN),
  .NUM_OUT     (NUM_OUT),
  .TABLE_BITS  (TABLE_BITS),
  .STACK_DEPTH (STACK_DEPTH)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_en      (run_en),
  .in_bus      (in_bus),
  .out_bus     (out_bus),
  .scan_done   (scan_done),
  .mem_we      (mem_we),
  .exec_active (exec_active),
  .coil_we     (coil_we),
  .sample_en   (sample_en),
  .table_bits  (table_bits),
  .stack_depth (stack_depth)
);

// File: tb/lscan_engine_bench.sv
module lscan_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic [7:0] in_bus = '0;
  logic       prog_we = 1'b0;
  logic [4:0] prog_addr = '0;
  logic [9:0] prog_data = '0;
  logic [7:0] out_bus;
  logic       scan_done;

  int checks = 0;
  int failures = 0;

  logic [9:0]  prog_m [32];
  logic [63:0] tbl_m = '0;
  logic [7:0]  out_m = '0;

  always #10 clk = ~clk;

  lscan_engine u_lscan_engine (
    .clk(clk), .rst(rst), .run_en(run_en), .in_bus(in_bus),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .out_bus(out_bus), .scan_done(scan_done)
  );

  function automatic logic [9:0] mk(input int op, input int a);
    return {op[3:0], a[5:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference scan: freeze inputs, run slots in order, publish output window.
  task automatic model_scan(input logic [7:0] inb);
    logic acc; logic [3:0] stk; int sp; logic [3:0] op; logic [5:0] a; logic c;
    acc = 1'b0; sp = 0; stk = '0;
    tbl_m[7:0] = inb;
    for (int p = 0; p < 31; p++) begin
      op = prog_m[p][9:6]; a = prog_m[p][5:0];
      if (op >= 4'd9) break;
      c = tbl_m[a] ^ op[0];
      case (op)
        4'd0, 4'd1: acc = c;
        4'd2, 4'd3: acc = acc & c;
        4'd4, 4'd5: acc = acc | c;
        4'd6: begin if (sp < 4) begin stk[sp] = acc; sp++; end acc = 1'b1; end
        4'd7: begin if (sp > 0) begin sp--; acc = acc & stk[sp]; end end
        default: tbl_m[a] = acc;
      endcase
    end
    out_m = tbl_m[15:8];
  endtask

  function automatic int model_len();
    for (int p = 0; p < 31; p++) if (prog_m[p][9:6] >= 4'd9) return p + 1;
    return 32;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; run_en = 1'b0; prog_we = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    tbl_m = '0; out_m = '0;
  endtask

  task automatic load(input int addr, input logic [9:0] data);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = addr[4:0]; prog_data = data;
    @(negedge clk);
    prog_we = 1'b0;
    prog_m[addr] = data;
  endtask

  // Single scan; optional late input change and optional locked-out write.
  task automatic run_scan(input logic [7:0] inb, input bit alt, input logic [7:0] alt_in,
                          input bit poke, input logic [4:0] paddr, input logic [9:0] pdata,
                          output int cyc);
    logic [7:0] prev; bit stable_ok;
    prev = out_bus; stable_ok = 1'b1; cyc = 0;
    @(negedge clk);
    in_bus = inb; run_en = 1'b1;
    if (poke) begin prog_we = 1'b1; prog_addr = paddr; prog_data = pdata; end
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && alt) in_bus = alt_in;
      if (cyc == 2) prog_we = 1'b0;
      if (scan_done) break;
      if (out_bus !== prev) stable_ok = 1'b0;
      if (cyc > 300) begin
        check(1'b0, "R7 watchdog scan", cyc, 0);
        break;
      end
    end
    run_en = 1'b0; prog_we = 1'b0;
    model_scan(inb);
    check(out_bus === out_m, "R3/R4/R5 scan output", out_bus, out_m);
    check(stable_ok, "R8 output held during scan", stable_ok, 1);
  endtask

  int cyc;
  logic [7:0] v;
  logic [7:0] prev6;

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) prog_m[i] = mk(9, 0);
    do_reset();
    // R1 reset state at the ports
    check(out_bus === 8'h00, "R1 out after reset", out_bus, 0);
    check(scan_done === 1'b0, "R1 done after reset", scan_done, 0);

    // Combinational program P1
    load(0, mk(0, 0));  load(1, mk(8, 8));
    load(2, mk(1, 1));  load(3, mk(8, 9));
    load(4, mk(0, 2));  load(5, mk(3, 3));  load(6, mk(8, 10));
    load(7, mk(0, 4));  load(8, mk(4, 5));  load(9, mk(8, 11));
    load(10, mk(0, 0)); load(11, mk(6, 0)); load(12, mk(0, 1));
    load(13, mk(5, 2)); load(14, mk(7, 0)); load(15, mk(8, 12));
    load(16, mk(0, 40)); load(17, mk(8, 13));
    load(18, mk(0, 6)); load(19, mk(8, 40));
    load(20, mk(0, 40)); load(21, mk(8, 14));
    load(22, mk(9, 0));

    prev6 = 1'b0;
    foreach (v[k]) ; // no-op keeps v typed
    for (int t = 0; t < 4; t++) begin
      logic [7:0] p, e;
      p = (t == 0) ? 8'h00 : (t == 1) ? 8'hFF : (t == 2) ? 8'h45 : 8'hB2;
      run_scan(p, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
      e = out_bus;
      check(e[0] === p[0], "R3 normally-open contact", e[0], p[0]);
      check(e[1] === ~p[1], "R3 normally-closed contact", e[1], ~p[1]);
      check(e[2] === (p[2] & ~p[3]), "R3 series AND-NC", e[2], p[2] & ~p[3]);
      check(e[3] === (p[4] | p[5]), "R3 parallel OR", e[3], p[4] | p[5]);
      check(e[4] === (p[0] & (p[1] | ~p[2])), "R4 branch", e[4], p[0] & (p[1] | ~p[2]));
      check(e[5] === prev6, "R5 read before coil sees old value", e[5], prev6);
      check(e[6] === p[6], "R5 read after coil sees new value", e[6], p[6]);
      check(cyc == 24, "R7 scan length L+1", cyc, 24);
      prev6 = p[6];
    end

    // R2 inputs frozen at start edge
    run_scan(8'h01, 1'b1, 8'hFE, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[0] === 1'b1, "R2 late input change ignored", out_bus[0], 1);

    // Latch program P2 on bit 15 (out7): set=in0, reset=in1
    load(0, mk(0, 0)); load(1, mk(4, 15)); load(2, mk(3, 1));
    load(3, mk(8, 15)); load(4, mk(9, 0));
    run_scan(8'h01, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7] === 1'b1, "R6 latch set", out_bus[7], 1);
    run_scan(8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7] === 1'b1, "R6 latch holds", out_bus[7], 1);
    run_scan(8'h02, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7] === 1'b0, "R6 latch reset", out_bus[7], 0);
    run_scan(8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7] === 1'b0, "R6 latch stays clear", out_bus[7], 0);
    run_scan(8'h03, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7] === 1'b0, "R6 set with reset clears", out_bus[7], 0);

    // R9 write during start and scan ignored (would redirect coil to bit 14)
    run_scan(8'h01, 1'b0, 8'h00, 1'b1, 5'd3, mk(8, 14), cyc);
    run_scan(8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7:6] === 2'b10, "R9 locked-out write ignored", out_bus[7:6], 2'b10);

    // R10 continuous scanning, then stop
    begin
      int gap; bit extra;
      @(negedge clk); in_bus = 8'h00; run_en = 1'b1; gap = 0;
      for (int s = 0; s < 3; s++) begin
        gap = 0;
        do begin @(negedge clk); gap++; end while (!scan_done && gap < 300);
        model_scan(8'h00);
        check(gap == 6, "R10 back-to-back period", gap, 6);
        check(out_bus === out_m, "R10 continuous output", out_bus, out_m);
        if (s == 2) run_en = 1'b0;
      end
      extra = 1'b0;
      for (int w = 0; w < 20; w++) begin @(negedge clk); if (scan_done) extra = 1'b1; end
      check(!extra, "R10 stops when run_en low", extra, 0);
    end

    // R1 reset clears table (latch bit) but keeps program
    run_scan(8'h01, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    do_reset();
    check(out_bus === 8'h00, "R1 out cleared", out_bus, 0);
    run_scan(8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(out_bus[7] === 1'b0, "R1 table cleared, latch off", out_bus[7], 0);

    // R7 last slot forces end: no END, slot 31 coil must not run
    for (int i = 0; i < 30; i += 2) begin load(i, mk(0, 0)); load(i + 1, mk(8, 8)); end
    load(30, mk(1, 0)); load(31, mk(8, 9));
    run_scan(8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
    check(cyc == 33, "R7 full program length", cyc, 33);
    check(out_bus[1] === 1'b0, "R7 last slot not executed", out_bus[1], 0);

    // Random programs against the reference
    do_reset();
    for (int it = 0; it < 30; it++) begin
      int pos; pos = 0;
      while (pos <= 20) begin
        load(pos, mk($urandom % 2, $urandom % 64)); pos++;
        for (int k = $urandom % 3; k > 0; k--) begin
          load(pos, mk(2 + $urandom % 4, $urandom % 64)); pos++;
        end
        if ($urandom % 2) begin
          load(pos, mk(6, 0)); load(pos + 1, mk($urandom % 2, $urandom % 64));
          load(pos + 2, mk(4 + $urandom % 2, $urandom % 64)); load(pos + 3, mk(7, 0));
          pos += 4;
        end
        load(pos, mk(8, 8 + $urandom % 56)); pos++;
      end
      load(pos, mk(9, 0));
      for (int s = 0; s < 3; s++) begin
        run_scan($urandom, 1'b0, 8'h00, 1'b0, 5'd0, 10'd0, cyc);
        check(cyc == model_len() + 1, "R7 random scan length", cyc, model_len() + 1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule